// File: doc/BRIEF.md
# Memory Access Fault Checker

This block sits beside the load/store and fetch paths of a small soft processor and decides, one access at a time, whether that access has faulted. It checks three things. The first is whether the address is aligned for the access width. The second is whether a stack access stays inside a programmed window. The third is whether the bus has reported an error for an instruction fetch or a data access. When a fault is recorded, the block writes a cause word and the faulting address into two registers. It also raises a one-cycle trap request toward the exception logic.

Each fault kind follows its own gating rule. A misaligned access is always recorded, but it traps only when exceptions are enabled. A stack window violation is recorded and traps no matter how the enable is set. A bus error does nothing at all while exceptions are disabled. When exceptions are enabled, a bus error captures the address, and it sets a cause and traps only if the configuration bit for that bus allows it. For a misaligned access, the cause word also carries the access width, the direction and the destination register number, so a handler can replay or emulate the access.

Top module: `mem_fault_chk`

## Requirements
- R1: An access is misaligned when the low two address bits ANDed with `align_mask` are nonzero. The mask encodings are 2'b00 for no alignment check, 2'b01 for a halfword access and 2'b11 for a word access.
- R2: A recorded misalignment writes a cause word with code 5'h01 in bits 4:0, `dst_reg` in bits 9:5 and `acc_wr` in bit 10. Bit 11 is set exactly when `align_mask` is 2'b11.
- R3: A misalignment writes `fault_addr` and `cause` whatever the value of `exc_en`. It pulses `trap_req` only when `exc_en` is 1.
- R4: With `stk_chk` high, an address below `stk_lo` or above `stk_hi` (unsigned) is a violation. An address equal to either bound is not. A violation writes the address and a cause of 5'h07 in bits 4:0 with bits 11:5 zero, and it pulses `trap_req` even when `exc_en` is 0.
- R5: While `exc_en` is 0, a bus error leaves `cause` and `fault_addr` unchanged and does not pulse `trap_req`.
- R6: While `exc_en` is 1, a bus error always captures the address. If `bus_is_insn` is 1 and `cfg_ibus_exc` is 1, the cause becomes 5'h03 and a trap is requested. If `bus_is_insn` is 0 and `cfg_dbus_exc` is 1, the cause becomes 5'h04 and a trap is requested. When the matching configuration bit is 0, the cause is unchanged and no trap is requested.
- R7: When faults coincide, a stack violation wins over a misalignment, and a misalignment wins over a bus error. Only the winner's effects apply.
- R8: Reset clears `cause`, `fault_addr` and `trap_req`. Both registers hold their value in cycles with no recorded fault. `trap_req` is high for the single cycle after the edge that sampled the trapping access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | ADDR_W | Address of the access under check |
| align_mask | input | 2 | Alignment mask: 00 none, 01 halfword, 11 word |
| acc_wr | input | 1 | Access is a store |
| dst_reg | input | REG_W | Destination/source register number of the access |
| stk_chk | input | 1 | Access uses the stack pointer and is window-checked |
| stk_lo | input | ADDR_W | Lowest legal stack address |
| stk_hi | input | ADDR_W | Highest legal stack address |
| bus_err | input | 1 | Bus reported an error for this access |
| bus_is_insn | input | 1 | The erroring access was an instruction fetch |
| exc_en | input | 1 | Exceptions enabled |
| cfg_ibus_exc | input | 1 | Instruction-bus errors may raise exceptions |
| cfg_dbus_exc | input | 1 | Data-bus errors may raise exceptions |
| cause | output | REG_W+7 | Exception cause register |
| fault_addr | output | ADDR_W | Exception address register |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The bench builds the block with its defaults: 32-bit addresses and 5-bit register numbers. With these values the cause word is 12 bits wide and the width and direction bits land at bits 11 and 10. At 32 bits, the bench can place stack bounds near the top of the address space, so the above-bound case with an all-ones address is reachable. Register numbers up to 31 also reach the full destination field. The stimulus covers each fault alone, each fault against both enable settings and both bus configuration bits, addresses sitting exactly on the stack bounds, and coinciding faults that exercise the priority order.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
    localparam int CODE_W = 5;
    localparam logic [CODE_W-1:0] CODE_NONE     = 5'h00;
    localparam logic [CODE_W-1:0] CODE_MISALIGN = 5'h01;
    localparam logic [CODE_W-1:0] CODE_IBUS     = 5'h03;
    localparam logic [CODE_W-1:0] CODE_DBUS     = 5'h04;
    localparam logic [CODE_W-1:0] CODE_STACK    = 5'h07;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_STACK = 2'd1,
        WIN_ALIGN = 2'd2,
        WIN_BUS   = 2'd3
    } win_e;
endpackage

// File: rtl/mfc_align.sv
module mfc_align #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] mask,
    output logic              hit,
    output logic              is_word
);
    always_comb begin
        hit     = |(addr[MASK_W-1:0] & mask);
        is_word = &mask;
    end
endmodule

// File: rtl/mfc_stack.sv
module mfc_stack #(
    parameter int ADDR_W = 32
) (
    input  logic              chk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit
);
    logic below, above;
    always_comb begin
        below = addr < lo;
        above = addr > hi;
        hit   = chk && (below || above);
    end
endmodule

// File: rtl/mfc_bus.sv
module mfc_bus
    import mfc_pkg::*;
(
    input  logic              err,
    input  logic              exc_en,
    input  logic              is_insn,
    input  logic              cfg_i,
    input  logic              cfg_d,
    output logic              capture,
    output logic              raise,
    output logic [CODE_W-1:0] code
);
    logic allowed;
    always_comb begin
        allowed = is_insn ? cfg_i : cfg_d;
        capture = err && exc_en;
        raise   = capture && allowed;
        code    = is_insn ? CODE_IBUS : CODE_DBUS;
    end
endmodule

// File: rtl/mem_fault_chk.sv
module mem_fault_chk
    import mfc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [1:0]                 align_mask,
    input  logic                       acc_wr,
    input  logic [REG_W-1:0]           dst_reg,
    input  logic                       stk_chk,
    input  logic [ADDR_W-1:0]          stk_lo,
    input  logic [ADDR_W-1:0]          stk_hi,
    input  logic                       bus_err,
    input  logic                       bus_is_insn,
    input  logic                       exc_en,
    input  logic                       cfg_ibus_exc,
    input  logic                       cfg_dbus_exc,
    output logic [REG_W+CODE_W+1:0]    cause,
    output logic [ADDR_W-1:0]          fault_addr,
    output logic                       trap_req
);
    localparam int CAUSE_W = REG_W + CODE_W + 2;
    localparam int EXTRA_W = CAUSE_W - CODE_W;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [ADDR_W-1:0]  addr;
        logic               trap;
    } state_t;

    state_t st_d, st_q;
    win_e   win;

    logic              mis_hit, mis_word;
    logic              stk_hit;
    logic              bus_cap, bus_raise;
    logic [CODE_W-1:0] bus_code;

    mfc_align #(.ADDR_W(ADDR_W), .MASK_W(2)) u_align (
        .addr    (acc_addr),
        .mask    (align_mask),
        .hit     (mis_hit),
        .is_word (mis_word)
    );

    mfc_stack #(.ADDR_W(ADDR_W)) u_stack (
        .chk  (stk_chk),
        .addr (acc_addr),
        .lo   (stk_lo),
        .hi   (stk_hi),
        .hit  (stk_hit)
    );

    mfc_bus u_bus (
        .err     (bus_err),
        .exc_en  (exc_en),
        .is_insn (bus_is_insn),
        .cfg_i   (cfg_ibus_exc),
        .cfg_d   (cfg_dbus_exc),
        .capture (bus_cap),
        .raise   (bus_raise),
        .code    (bus_code)
    );

    // Priority select: stack window, then alignment, then bus.
    always_comb begin
        if (stk_hit)      win = WIN_STACK;
        else if (mis_hit) win = WIN_ALIGN;
        else if (bus_cap) win = WIN_BUS;
        else              win = WIN_NONE;
    end

    always_comb begin
        st_d       = st_q;
        st_d.trap  = 1'b0;
        unique case (win)
            WIN_STACK: begin
                st_d.addr  = acc_addr;
                st_d.cause = {{EXTRA_W{1'b0}}, CODE_STACK};
                st_d.trap  = 1'b1;
            end
            WIN_ALIGN: begin
                st_d.addr  = acc_addr;
                st_d.cause = {mis_word, acc_wr, dst_reg, CODE_MISALIGN};
                st_d.trap  = exc_en;
            end
            WIN_BUS: begin
                st_d.addr = acc_addr;
                if (bus_raise) begin
                    st_d.cause = {{EXTRA_W{1'b0}}, bus_code};
                    st_d.trap  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause      = st_q.cause;
    assign fault_addr = st_q.addr;
    assign trap_req   = st_q.trap;

    // R4: a window violation traps with the stack code regardless of enable
    p_stack_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stk_hit |=> trap_req && cause[CODE_W-1:0] == CODE_STACK);

    // R3: misalignment with traps off records the address but never traps
    p_mis_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_hit && !stk_hit && !exc_en) |=> !trap_req && fault_addr == $past(acc_addr));

    // R5: bus error with traps off touches nothing
    p_bus_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !exc_en && !mis_hit && !stk_hit)
        |=> $stable(cause) && $stable(fault_addr) && !trap_req);

    // R6: a masked bus error keeps the cause and raises no trap
    p_bus_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && exc_en && !mis_hit && !stk_hit
         && !(bus_is_insn ? cfg_ibus_exc : cfg_dbus_exc))
        |=> $stable(cause) && !trap_req);

    // R8: any trap carries a real cause code
    p_trap_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> cause[CODE_W-1:0] != CODE_NONE);
endmodule

// File: tb/tb_mem_fault_chk.sv
module tb_mem_fault_chk;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int RW = 5;
    localparam int CW = RW + 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    align_mask = '0;
    logic          acc_wr = 1'b0;
    logic [RW-1:0] dst_reg = '0;
    logic          stk_chk = 1'b0;
    logic [AW-1:0] stk_lo = '0;
    logic [AW-1:0] stk_hi = '0;
    logic          bus_err = 1'b0;
    logic          bus_is_insn = 1'b0;
    logic          exc_en = 1'b0;
    logic          cfg_ibus_exc = 1'b0;
    logic          cfg_dbus_exc = 1'b0;
    logic [CW-1:0] cause;
    logic [AW-1:0] fault_addr;
    logic          trap_req;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [CW-1:0] cause;
        logic [AW-1:0] addr;
        logic          trap;
        string         tag;
    } exp_t;

    exp_t q[$];
    logic [CW-1:0] m_cause = '0;
    logic [AW-1:0] m_addr = '0;
    bit            drv_done = 0;

    mem_fault_chk #(.ADDR_W(AW), .REG_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .align_mask(align_mask),
        .acc_wr(acc_wr), .dst_reg(dst_reg), .stk_chk(stk_chk), .stk_lo(stk_lo),
        .stk_hi(stk_hi), .bus_err(bus_err), .bus_is_insn(bus_is_insn),
        .exc_en(exc_en), .cfg_ibus_exc(cfg_ibus_exc), .cfg_dbus_exc(cfg_dbus_exc),
        .cause(cause), .fault_addr(fault_addr), .trap_req(trap_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [CW-1:0] ec, logic [AW-1:0] ea, logic et);
        n_chk++;
        if (cause !== ec || fault_addr !== ea || trap_req !== et) begin
            n_bad++;
            $display("FAIL %s: cause=%h addr=%h trap=%b expected cause=%h addr=%h trap=%b",
                     tag, cause, fault_addr, trap_req, ec, ea, et);
        end
    endtask

    // Driver: applies one access per cycle and pushes the modelled result.
    task automatic apply(string tag, logic [AW-1:0] a, logic [1:0] m, logic wr,
                         logic [RW-1:0] d, logic sc, logic be, logic bi,
                         logic en, logic ci, logic cd);
        exp_t e;
        logic sv, mv, ok;
        @(negedge clk);
        acc_addr = a; align_mask = m; acc_wr = wr; dst_reg = d; stk_chk = sc;
        bus_err = be; bus_is_insn = bi; exc_en = en; cfg_ibus_exc = ci; cfg_dbus_exc = cd;
        sv = sc && (a < stk_lo || a > stk_hi);
        mv = (a[1:0] & m) != 2'b00;
        e.trap = 1'b0;
        if (sv) begin
            m_addr = a; m_cause = {7'b0, 5'h07}; e.trap = 1'b1;
        end else if (mv) begin
            m_addr = a; m_cause = {(m == 2'b11), wr, d, 5'h01}; e.trap = en;
        end else if (be && en) begin
            m_addr = a;
            ok = bi ? ci : cd;
            if (ok) begin
                m_cause = {7'b0, (bi ? 5'h03 : 5'h04)}; e.trap = 1'b1;
            end
        end
        e.cause = m_cause; e.addr = m_addr; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares one queued item just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, e.cause, e.addr, e.trap);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        stk_lo = 32'h0000_1000;
        stk_hi = 32'hFFFF_FF00;
        repeat (3) @(negedge clk);
        check("R8 reset", '0, '0, 1'b0);
        rst_n = 1'b1;
        // name    addr           mask  wr  dst  stk  be  bi  en  ci  cd
        apply("R8 idle hold",    32'h0000_2000, 2'b11, 0, 5'd0, 0, 0, 0, 1, 1, 1);
        apply("R1 R2 word wr",   32'h0000_2002, 2'b11, 1, 5'd31, 0, 0, 0, 1, 0, 0);
        apply("R8 trap pulse",   32'h0000_2004, 2'b00, 0, 5'd0, 0, 0, 0, 1, 0, 0);
        apply("R1 R3 half off",  32'h0000_3001, 2'b01, 0, 5'd9, 0, 0, 0, 0, 0, 0);
        apply("R1 half aligned", 32'h0000_3002, 2'b01, 1, 5'd3, 0, 0, 0, 1, 0, 0);
        apply("R1 no check",     32'h0000_3003, 2'b00, 1, 5'd3, 0, 0, 0, 1, 0, 0);
        apply("R4 below lo",     32'h0000_0FFF, 2'b00, 0, 5'd1, 1, 0, 0, 1, 0, 0);
        apply("R4 equal lo",     32'h0000_1000, 2'b00, 0, 5'd1, 1, 0, 0, 1, 0, 0);
        apply("R4 equal hi",     32'hFFFF_FF00, 2'b00, 0, 5'd1, 1, 0, 0, 1, 0, 0);
        apply("R4 above hi off", 32'hFFFF_FFFF, 2'b00, 0, 5'd1, 1, 0, 0, 0, 0, 0);
        apply("R5 bus off",      32'h0000_5000, 2'b00, 0, 5'd0, 0, 1, 1, 0, 1, 1);
        apply("R6 ibus on",      32'h0000_6000, 2'b00, 0, 5'd0, 0, 1, 1, 1, 1, 0);
        apply("R6 dbus masked",  32'h0000_6100, 2'b00, 0, 5'd0, 0, 1, 0, 1, 1, 0);
        apply("R6 dbus on",      32'h0000_6200, 2'b00, 1, 5'd0, 0, 1, 0, 1, 0, 1);
        apply("R6 ibus masked",  32'h0000_6300, 2'b00, 0, 5'd0, 0, 1, 1, 1, 0, 1);
        apply("R7 stack wins",   32'h0000_0003, 2'b11, 1, 5'd7, 1, 1, 0, 1, 1, 1);
        apply("R7 align wins",   32'h0000_7001, 2'b11, 0, 5'd12, 0, 1, 1, 1, 1, 1);
        apply("R7 align off",    32'h0000_7003, 2'b01, 1, 5'd20, 0, 1, 0, 0, 1, 1);
        apply("R8 final hold",   32'h0000_8000, 2'b00, 0, 5'd0, 0, 0, 0, 1, 1, 1);
        @(negedge clk);
        @(negedge clk);
        drv_done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule